// File: doc/BRIEF.md
# Phase-Modulated Wavetable Voice

This block is one audio voice. Software loads a 64-entry table of 6-bit samples, and the voice steps through that table with a 25-bit phase accumulator. A 12-bit frequency value sets the carrier's phase step. A second, slower 18-bit accumulator walks a 32-entry table of 3-bit modulation codes. On each step the current code, scaled by an external modulation gain, gives a signed offset that is added to the carrier's step. This bends the pitch and gives vibrato or FM-like timbres.

All control comes from a single byte-wide write port:

- Addresses 0x00 to 0x3F hold the sample table.
- Addresses 0x40 to 0x45 hold the control registers.

An external envelope stage supplies two 6-bit gains: volume and modulation depth. An external tick (`step_en`) advances both accumulators and produces one scaled output sample. While software holds the table-unlock bit in the control register, the output is forced silent.

Top module: `wsv_voice`

## Requirements
- R1: After `rst_n` is held low across a clock edge, `sample_out` and `sample_valid` are 0. Both accumulators, all registers, the sample table and the modulation table are cleared.
- R2: A write to address 0x00–0x3F stores `cpu_wdata[5:0]` into that sample entry only if bit 7 of the control register (0x40) is 1. Otherwise the write has no effect.
- R3: While bit 7 of 0x40 is 1, every sample produced by a step is 0.
- R4: The carrier frequency is `{0x42[3:0], 0x41[7:0]}`. Bits 7:4 of 0x42 are ignored.
- R5: A write to 0x45 stores `cpu_wdata[2:0]` into the modulation table at the current index. The index then advances by one and wraps from 31 to 0.
- R6: The modulation frequency is `{0x44[3:0], 0x43[7:0]}`. Any write to 0x44 returns the table index and the modulation accumulator to 0.
- R7: On each step the 18-bit modulation accumulator adds the modulation frequency and wraps. The code used in a step is the table entry at accumulator bits 17:13, read before that step's add.
- R8: For code t with magnitude m = t[1:0], the offset is computed as follows:
  - If m = 0, the offset is 0.
  - If t[2] = 0, the offset is +2·gain·m.
  - If t[2] = 1, the offset is −2·gain·(4−m).
  - The result is then clamped to −128..127.
- R9: When 0x44 bit 7 is 1, the offset is 0.
- R10: On each step the 25-bit carrier accumulator adds max(0, carrier frequency + offset) and wraps. Between steps it holds its value. The sample index is accumulator bits 24:19, read before that step's add.
- R11: On the clock edge that samples `step_en`, `sample_out` becomes floor(sample·min(vol_gain,32)·4 / (0x40[1:0]+2)). `sample_valid` is high for exactly the cycle after each step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Write strobe for the register/table port |
| cpu_addr | input | 7 | Write address: bit 6 clear selects the sample table, set selects a control register |
| cpu_wdata | input | 8 | Write data |
| step_en | input | 1 | Sample tick: advances both accumulators and produces one sample |
| vol_gain | input | 6 | Volume gain from the envelope stage (values above 32 act as 32) |
| mod_gain | input | 6 | Modulation depth from the envelope stage |
| sample_out | output | 13 | Scaled output sample |
| sample_valid | output | 1 | High for one cycle after each step |

## Verification
Some properties are checked on every cycle by the assertions:

- The carrier phase holds still between ticks.
- A write to 0x44 always zeroes the modulation phase.
- Every table-port write moves the index forward by exactly one with wrap.
- A locked sample-table write leaves the entry untouched.
- A tick taken while unlocked yields silence.
- `sample_valid` tracks the tick one cycle later.
- The output never exceeds the largest value the scaling can produce.

The exact output values need the bench's scenarios. These are the arithmetic of each gain and divisor pairing, the signed offset with its clamping, and the carrier step pinned at zero by large negative offsets. They also include the effect of a table overrun wrapping onto entry 0 and a mid-run modulation restart. The bench compares every tick against an independent model of the requirements.

// File: rtl/wsv_pkg.sv
`timescale 1ns/1ps
// Shared constants for the wavetable voice: table geometry, accumulator
// widths and the register selector codes used under address bit 6.
package wsv_pkg;
    localparam int WAVE_DEPTH = 64;
    localparam int WAVE_W     = 6;
    localparam int MOD_DEPTH  = 32;
    localparam int MOD_W      = 3;
    localparam int FREQ_W     = 12;
    localparam int CAR_ACC_W  = 25;
    localparam int MOD_ACC_W  = 18;
    localparam int GAIN_W     = 6;
    localparam int GAIN_CAP   = 32;
    localparam int OFF_W      = 8;

    // Control register selectors (low address bits when bit 6 is set)
    localparam int SEL_CTRL    = 0;
    localparam int SEL_CAR_LO  = 1;
    localparam int SEL_CAR_HI  = 2;
    localparam int SEL_MOD_LO  = 3;
    localparam int SEL_MOD_HI  = 4;
    localparam int SEL_MOD_PRT = 5;
endpackage

// File: rtl/wsv_regfile.sv
`timescale 1ns/1ps
// Register file and the two tables of the voice.
// Decodes the byte write port: the lower half of the address space is the
// sample table, the upper half holds control, carrier/modulation frequency
// and the sequential modulation-table port. Assumes one write per cycle.
module wsv_regfile
    import wsv_pkg::*;
#(
    parameter int P_WAVE_DEPTH = WAVE_DEPTH,
    parameter int P_WAVE_W     = WAVE_W,
    parameter int P_MOD_DEPTH  = MOD_DEPTH,
    parameter int P_MOD_W      = MOD_W,
    parameter int P_FREQ_W     = FREQ_W,
    localparam int WAVE_AW     = $clog2(P_WAVE_DEPTH),
    localparam int MOD_AW      = $clog2(P_MOD_DEPTH),
    localparam int HI_W        = P_FREQ_W - 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WAVE_AW:0]    wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [WAVE_AW-1:0]  wave_idx,
    input  logic [MOD_AW-1:0]   mod_idx,
    output logic [P_WAVE_W-1:0] wave_sample,
    output logic [P_MOD_W-1:0]  mod_code,
    output logic [P_FREQ_W-1:0] car_freq,
    output logic [P_FREQ_W-1:0] mod_freq,
    output logic                mod_off,
    output logic                unlock,
    output logic [1:0]          div_sel,
    output logic                mod_restart
);
    logic [P_WAVE_W-1:0] wave_mem [P_WAVE_DEPTH];
    logic [P_MOD_W-1:0]  mod_mem  [P_MOD_DEPTH];
    logic [MOD_AW-1:0]   wr_idx;
    logic [7:0]          ctrl_q;
    logic [7:0]          car_lo_q;
    logic [HI_W-1:0]     car_hi_q;
    logic [7:0]          mod_lo_q;
    logic [HI_W-1:0]     mod_hi_q;
    logic                mod_dis_q;

    logic                is_reg;
    logic [WAVE_AW-1:0]  sel;
    logic                wave_wr;
    logic                port_wr;

    // Purpose: split the write into a table or register access
    always_comb begin
        is_reg      = wr_addr[WAVE_AW];
        sel         = wr_addr[WAVE_AW-1:0];
        wave_wr     = wr_en && !is_reg && ctrl_q[7];
        port_wr     = wr_en && is_reg && (sel == WAVE_AW'(SEL_MOD_PRT));
        mod_restart = wr_en && is_reg && (sel == WAVE_AW'(SEL_MOD_HI));
    end

    // Purpose: hold the control and frequency registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            car_lo_q  <= '0;
            car_hi_q  <= '0;
            mod_lo_q  <= '0;
            mod_hi_q  <= '0;
            mod_dis_q <= 1'b0;
        end else if (wr_en && is_reg) begin
            case (sel)
                WAVE_AW'(SEL_CTRL):   ctrl_q   <= wr_data;
                WAVE_AW'(SEL_CAR_LO): car_lo_q <= wr_data;
                WAVE_AW'(SEL_CAR_HI): car_hi_q <= wr_data[HI_W-1:0];
                WAVE_AW'(SEL_MOD_LO): mod_lo_q <= wr_data;
                WAVE_AW'(SEL_MOD_HI): begin
                    mod_hi_q  <= wr_data[HI_W-1:0];
                    mod_dis_q <= wr_data[7];
                end
                default: ;
            endcase
        end
    end

    // Purpose: sample table, writable only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < P_WAVE_DEPTH; i++) wave_mem[i] <= '0;
        end else if (wave_wr) begin
            wave_mem[wr_addr[WAVE_AW-1:0]] <= wr_data[P_WAVE_W-1:0];
        end
    end

    // Purpose: modulation table with post-incrementing write index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < P_MOD_DEPTH; i++) mod_mem[i] <= '0;
            wr_idx <= '0;
        end else if (mod_restart) begin
            wr_idx <= '0;
        end else if (port_wr) begin
            mod_mem[wr_idx] <= wr_data[P_MOD_W-1:0];
            wr_idx          <= wr_idx + MOD_AW'(1);
        end
    end

    // Purpose: present register fields and table reads
    always_comb begin
        wave_sample = wave_mem[wave_idx];
        mod_code    = mod_mem[mod_idx];
        car_freq    = {car_hi_q, car_lo_q};
        mod_freq    = {mod_hi_q, mod_lo_q};
        mod_off     = mod_dis_q;
        unlock      = ctrl_q[7];
        div_sel     = ctrl_q[1:0];
    end

    // R5: each port write moves the index forward by one, wrapping
    a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> wr_idx == $past(wr_idx) + MOD_AW'(1));

    // R2: a locked sample write leaves the addressed entry unchanged
    a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_reg && !ctrl_q[7]) |=>
            wave_mem[$past(wr_addr[WAVE_AW-1:0])] == $past(wave_mem[wr_addr[WAVE_AW-1:0]]));
endmodule

// File: rtl/wsv_modulator.sv
`timescale 1ns/1ps
// Modulation path: an 18-bit phase accumulator whose top bits pick a
// modulation code, and the signed offset derived from that code and the
// external modulation gain. Assumes the code read is combinational.
module wsv_modulator
    import wsv_pkg::*;
#(
    parameter int P_ACC_W   = MOD_ACC_W,
    parameter int P_FREQ_W  = FREQ_W,
    parameter int P_MOD_W   = MOD_W,
    parameter int P_IDX_W   = $clog2(MOD_DEPTH),
    parameter int P_GAIN_W  = GAIN_W,
    parameter int P_OFF_W   = OFF_W,
    localparam int MAG_W    = P_MOD_W - 1,
    localparam int RAW_W    = P_GAIN_W + MAG_W + 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_en,
    input  logic                      restart,
    input  logic [P_FREQ_W-1:0]       mod_freq,
    input  logic                      mod_off,
    input  logic [P_GAIN_W-1:0]       mod_gain,
    input  logic [P_MOD_W-1:0]        mod_code,
    output logic [P_IDX_W-1:0]        mod_idx,
    output logic signed [P_OFF_W-1:0] offset
);
    localparam int OFF_MAX = (1 << (P_OFF_W - 1)) - 1;
    localparam int OFF_MIN = -(1 << (P_OFF_W - 1));

    logic [P_ACC_W-1:0]     mod_acc;
    logic [MAG_W-1:0]       mag;
    logic                   neg;
    logic [MAG_W:0]         mult;
    logic [RAW_W-1:0]       prod;
    logic signed [RAW_W-1:0] raw;

    // Purpose: advance the modulation phase on ticks, clear on restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            mod_acc <= '0;
        end else if (step_en) begin
            mod_acc <= mod_acc + P_ACC_W'(mod_freq);
        end
    end

    // Purpose: form the signed, doubled and clamped phase offset
    always_comb begin
        mod_idx = mod_acc[P_ACC_W-1 -: P_IDX_W];
        mag     = mod_code[MAG_W-1:0];
        neg     = mod_code[P_MOD_W-1];
        mult    = neg ? ((MAG_W+1)'(1 << MAG_W) - {1'b0, mag}) : {1'b0, mag};
        prod    = RAW_W'(mod_gain) * RAW_W'(mult);
        raw     = neg ? -$signed(prod << 1) : $signed(prod << 1);
        if (mod_off || mag == '0)
            offset = '0;
        else if (raw > RAW_W'(OFF_MAX))
            offset = P_OFF_W'(OFF_MAX);
        else if (raw < RAW_W'(OFF_MIN))
            offset = P_OFF_W'(OFF_MIN);
        else
            offset = raw[P_OFF_W-1:0];
    end

    // R6: a restart always leaves the modulation phase at zero
    a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> mod_acc == '0);

    // R7: the modulation phase only moves on a tick or a restart
    a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !restart) |=> $stable(mod_acc));
endmodule

// File: rtl/wsv_carrier.sv
`timescale 1ns/1ps
// Carrier phase accumulator. Adds the carrier frequency plus the signed
// modulation offset on each tick, never stepping backwards. The top bits
// of the accumulator index the sample table.
module wsv_carrier
    import wsv_pkg::*;
#(
    parameter int P_ACC_W  = CAR_ACC_W,
    parameter int P_FREQ_W = FREQ_W,
    parameter int P_OFF_W  = OFF_W,
    parameter int P_IDX_W  = $clog2(WAVE_DEPTH),
    localparam int SUM_W   = P_FREQ_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_en,
    input  logic [P_FREQ_W-1:0]       car_freq,
    input  logic signed [P_OFF_W-1:0] offset,
    output logic [P_IDX_W-1:0]        wave_idx
);
    logic [P_ACC_W-1:0] car_acc;
    logic [SUM_W-1:0]   sum;
    logic [SUM_W-2:0]   step_amt;

    // Purpose: bent step, floored at zero
    always_comb begin
        sum      = {2'b00, car_freq} + {{(SUM_W-P_OFF_W){offset[P_OFF_W-1]}}, offset};
        step_amt = sum[SUM_W-1] ? '0 : sum[SUM_W-2:0];
        wave_idx = car_acc[P_ACC_W-1 -: P_IDX_W];
    end

    // Purpose: advance the carrier phase on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_acc <= '0;
        end else if (step_en) begin
            car_acc <= car_acc + P_ACC_W'(step_amt);
        end
    end

    // R10: the carrier phase holds between ticks
    a_r10_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(car_acc));
endmodule

// File: rtl/wsv_scaler.sv
`timescale 1ns/1ps
// Output stage: multiplies the current sample by the capped volume gain
// and four, divides by one of four constant divisors and registers the
// result on each tick. Forces silence while the sample table is unlocked.
module wsv_scaler
    import wsv_pkg::*;
#(
    parameter int P_WAVE_W  = WAVE_W,
    parameter int P_GAIN_W  = GAIN_W,
    parameter int P_CAP     = GAIN_CAP,
    localparam int PROD_W   = P_WAVE_W + P_GAIN_W + 2,
    localparam int OUT_W    = PROD_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic                mute,
    input  logic [1:0]          div_sel,
    input  logic [P_WAVE_W-1:0] wave_sample,
    input  logic [P_GAIN_W-1:0] vol_gain,
    output logic [OUT_W-1:0]    sample_out,
    output logic                sample_valid
);
    localparam int OUT_PEAK = ((1 << P_WAVE_W) - 1) * P_CAP * 2;

    logic [P_GAIN_W-1:0] gain_c;
    logic [PROD_W-1:0]   prod;
    logic [PROD_W-1:0]   quot;

    // Purpose: cap the gain, scale and divide
    always_comb begin
        gain_c = (vol_gain > P_GAIN_W'(P_CAP)) ? P_GAIN_W'(P_CAP) : vol_gain;
        prod   = (PROD_W'(wave_sample) * PROD_W'(gain_c)) << 2;
        case (div_sel)
            2'd0:    quot = prod >> 1;
            2'd1:    quot = prod / PROD_W'(3);
            2'd2:    quot = prod >> 2;
            default: quot = prod / PROD_W'(5);
        endcase
    end

    // Purpose: register one sample per tick and flag it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out   <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= step_en;
            if (step_en) sample_out <= mute ? '0 : quot[OUT_W-1:0];
        end
    end

    // R3: a tick taken while unlocked gives silence
    a_r3_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mute) |=> sample_out == '0);

    // R11: valid follows the tick by exactly one cycle
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> sample_valid);
    a_r11_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> !sample_valid);

    // R11: output never exceeds the largest scaled value
    a_r11_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sample_out <= OUT_W'(OUT_PEAK));
endmodule

// File: rtl/wsv_voice.sv
`timescale 1ns/1ps
// Top of the phase-modulated wavetable voice. Wires the register file,
// modulator, carrier accumulator and output scaler. Envelope gains come
// from outside; one sample is produced per step_en pulse.
module wsv_voice
    import wsv_pkg::*;
#(
    parameter int P_WAVE_DEPTH = WAVE_DEPTH,
    parameter int P_WAVE_W     = WAVE_W,
    parameter int P_MOD_DEPTH  = MOD_DEPTH,
    parameter int P_MOD_W      = MOD_W,
    parameter int P_FREQ_W     = FREQ_W,
    parameter int P_CAR_ACC_W  = CAR_ACC_W,
    parameter int P_MOD_ACC_W  = MOD_ACC_W,
    parameter int P_GAIN_W     = GAIN_W,
    parameter int P_OFF_W      = OFF_W,
    localparam int WAVE_AW     = $clog2(P_WAVE_DEPTH),
    localparam int MOD_AW      = $clog2(P_MOD_DEPTH),
    localparam int OUT_W       = P_WAVE_W + P_GAIN_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_wr,
    input  logic [WAVE_AW:0]    cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                step_en,
    input  logic [P_GAIN_W-1:0] vol_gain,
    input  logic [P_GAIN_W-1:0] mod_gain,
    output logic [OUT_W-1:0]    sample_out,
    output logic                sample_valid
);
    logic [WAVE_AW-1:0]        wave_idx;
    logic [MOD_AW-1:0]         mod_idx;
    logic [P_WAVE_W-1:0]       wave_sample;
    logic [P_MOD_W-1:0]        mod_code;
    logic [P_FREQ_W-1:0]       car_freq;
    logic [P_FREQ_W-1:0]       mod_freq;
    logic                      mod_off;
    logic                      unlock;
    logic [1:0]                div_sel;
    logic                      mod_restart;
    logic signed [P_OFF_W-1:0] offset;

    wsv_regfile #(
        .P_WAVE_DEPTH(P_WAVE_DEPTH), .P_WAVE_W(P_WAVE_W),
        .P_MOD_DEPTH(P_MOD_DEPTH), .P_MOD_W(P_MOD_W), .P_FREQ_W(P_FREQ_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .wr_addr(cpu_addr),
        .wr_data(cpu_wdata), .wave_idx(wave_idx), .mod_idx(mod_idx),
        .wave_sample(wave_sample), .mod_code(mod_code), .car_freq(car_freq),
        .mod_freq(mod_freq), .mod_off(mod_off), .unlock(unlock),
        .div_sel(div_sel), .mod_restart(mod_restart)
    );

    wsv_modulator #(
        .P_ACC_W(P_MOD_ACC_W), .P_FREQ_W(P_FREQ_W), .P_MOD_W(P_MOD_W),
        .P_IDX_W(MOD_AW), .P_GAIN_W(P_GAIN_W), .P_OFF_W(P_OFF_W)
    ) u_mod (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .restart(mod_restart),
        .mod_freq(mod_freq), .mod_off(mod_off), .mod_gain(mod_gain),
        .mod_code(mod_code), .mod_idx(mod_idx), .offset(offset)
    );

    wsv_carrier #(
        .P_ACC_W(P_CAR_ACC_W), .P_FREQ_W(P_FREQ_W), .P_OFF_W(P_OFF_W),
        .P_IDX_W(WAVE_AW)
    ) u_car (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .car_freq(car_freq),
        .offset(offset), .wave_idx(wave_idx)
    );

    wsv_scaler #(
        .P_WAVE_W(P_WAVE_W), .P_GAIN_W(P_GAIN_W), .P_CAP(GAIN_CAP)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .mute(unlock),
        .div_sel(div_sel), .wave_sample(wave_sample), .vol_gain(vol_gain),
        .sample_out(sample_out), .sample_valid(sample_valid)
    );
endmodule

// File: tb/wsv_voice_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a scaling vector table, then directed runs checked
// tick by tick against a model written from the requirements.
module wsv_voice_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [6:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        step_en = 1'b0;
    logic [5:0]  vol_gain = '0;
    logic [5:0]  mod_gain = '0;
    logic [12:0] sample_out;
    logic        sample_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model state
    int m_wave [64];
    int m_tab  [32];
    int m_idx, m_macc, m_cacc, m_ctrl, m_cf, m_mf, m_dis;

    // {sample, volume, divider select, expected}
    localparam int VEC [8][4] = '{
        '{63, 32, 0, 4032}, '{63, 63, 0, 4032}, '{10, 5, 1, 66},
        '{63, 32, 3, 1612}, '{1, 1, 2, 1},      '{0, 20, 0, 0},
        '{50, 33, 2, 1600}, '{45, 31, 1, 1860}
    };

    wsv_voice u_wsv_voice (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .step_en(step_en), .vol_gain(vol_gain),
        .mod_gain(mod_gain), .sample_out(sample_out), .sample_valid(sample_valid)
    );

    always #2.5 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_wave[i] = 0;
        for (int i = 0; i < 32; i++) m_tab[i] = 0;
        m_idx = 0; m_macc = 0; m_cacc = 0; m_ctrl = 0;
        m_cf = 0; m_mf = 0; m_dis = 0;
    endtask

    function automatic int mod_offset(int t, int g);
        int mag = t & 3;
        int v;
        if (mag == 0) return 0;
        v = ((t & 4) != 0) ? -g * (4 - mag) : g * mag;
        v = v * 2;
        if (v > 127) v = 127;
        if (v < -128) v = -128;
        return v;
    endfunction

    function automatic int scaled(int w, int vol, int dsel);
        int g = (vol > 32) ? 32 : vol;
        return (w * g * 4) / (dsel + 2);
    endfunction

    task automatic wr(int addr, int data);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 7'(addr); cpu_wdata = 8'(data);
        @(negedge clk);
        cpu_wr = 1'b0;
        if (addr < 64) begin
            if ((m_ctrl & 8'h80) != 0) m_wave[addr] = data & 63;
        end else begin
            case (addr)
                8'h40: m_ctrl = data;
                8'h41: m_cf = (m_cf & 12'hF00) | data;
                8'h42: m_cf = (m_cf & 12'h0FF) | ((data & 15) << 8);
                8'h43: m_mf = (m_mf & 12'hF00) | data;
                8'h44: begin
                    m_mf = (m_mf & 12'h0FF) | ((data & 15) << 8);
                    m_dis = (data >> 7) & 1; m_idx = 0; m_macc = 0;
                end
                8'h45: begin
                    m_tab[m_idx] = data & 7; m_idx = (m_idx + 1) & 31;
                end
                default: ;
            endcase
        end
    endtask

    // one tick; returns the sample produced
    task automatic tick(output int act);
        @(negedge clk); step_en = 1'b1;
        @(negedge clk); step_en = 1'b0;
        act = int'(sample_out);
    endtask

    // one tick checked against the model
    task automatic mstep(string tag);
        int exp, off, s, act;
        exp = ((m_ctrl & 8'h80) != 0) ? 0
              : scaled(m_wave[(m_cacc >> 19) & 63], int'(vol_gain), m_ctrl & 3);
        off = (m_dis != 0) ? 0 : mod_offset(m_tab[(m_macc >> 13) & 31], int'(mod_gain));
        s = m_cf + off;
        if (s < 0) s = 0;
        m_cacc = (m_cacc + s) & 32'h1FF_FFFF;
        m_macc = (m_macc + m_mf) & 32'h3_FFFF;
        tick(act);
        check(tag, act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int act;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 sample after reset", int'(sample_out), 0);
        check("R1 valid after reset", int'(sample_valid), 0);

        // R11: scaling vectors (carrier idle at index 0)
        for (int i = 0; i < 8; i++) begin
            wr(8'h40, 8'h80 | VEC[i][2]);
            wr(8'h00, VEC[i][0]);
            wr(8'h40, VEC[i][2]);
            vol_gain = 6'(VEC[i][1]);
            @(negedge clk); step_en = 1'b1;
            @(negedge clk); step_en = 1'b0;
            check("R11 scaled sample", int'(sample_out), VEC[i][3]);
            check("R11 valid pulse", int'(sample_valid), 1);
            @(negedge clk);
            check("R11 valid drops", int'(sample_valid), 0);
        end

        // R3: unlocked gives silence
        wr(8'h40, 8'h81);
        tick(act);
        check("R3 muted sample", act, 0);

        // R2: locked write ignored, entry 0 still 45
        wr(8'h40, 8'h01);
        wr(8'h00, 7);
        tick(act);
        check("R2 locked write ignored", act, 1860);

        // load sample table and modulation table (33 writes: R5 wrap)
        wr(8'h40, 8'h81);
        for (int i = 0; i < 64; i++) wr(i, (i * 5 + 3) & 63);
        wr(8'h40, 8'h01);
        wr(8'h44, 8'h03);
        for (int k = 0; k < 33; k++) wr(8'h45, (k * 3 + 1) & 7);
        vol_gain = 6'd40;
        mod_gain = 6'd63;
        // R4: high nibble of 0x42 ignored
        wr(8'h41, 8'hFF);
        wr(8'h42, 8'hFF);
        wr(8'h43, 8'h80);
        for (int i = 0; i < 1500; i++) mstep("R4 R5 R7 R8 R10 modulated run");

        // R10: small carrier, negative offsets floor the step
        wr(8'h41, 8'h30);
        wr(8'h42, 8'hF0);
        mod_gain = 6'd21;
        for (int i = 0; i < 300; i++) mstep("R8 R10 floored step");

        // R9: modulation disabled
        wr(8'h42, 8'h0F);
        wr(8'h44, 8'h83);
        for (int i = 0; i < 300; i++) mstep("R9 modulation off");

        // R6: restart mid-run, then rewrite entries from index 0
        wr(8'h44, 8'h05);
        wr(8'h45, 8'h04);
        wr(8'h45, 8'h07);
        for (int i = 0; i < 300; i++) mstep("R6 restart and reload");

        // R1: reset mid-run clears tables and phases
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        check("R1 sample after mid-run reset", int'(sample_out), 0);
        mstep("R1 cleared table after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule